// File: doc/BRIEF.md
# Two-Level Interrupt Request Controller

This block collects six interrupt requests and presents one of them to a CPU. There are two external event inputs, three timer overflows and one serial-port request. Software writes an enable register and a priority register. The enable register holds one bit per source and a global bit that masks every source at once. The priority register places each source at either the low level or the high level.

The controller picks a winner among the eligible requests. It raises a request line and gives the index of the winning source. When the CPU takes the vector, it pulses an acknowledge. The controller then marks that level as in service, and for edge-type sources it clears the latched flag. A high-level request may interrupt a low-level handler. Nothing interrupts a high-level handler, and a low-level request never interrupts any handler. A return-from-interrupt pulse releases the most recent level. A wake output tells the idle-mode logic that some enabled request is pending.

Top module: `intc_two_level`

## Requirements
- R1: After reset the enable and priority registers read 0, no level is in service, and both irq_req and wake are 0.
- R2: The enable register has bit 7 as the global enable and bits 5..0 as per-source enables. Source indices are 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial, 5 = timer 2. Bit 6 always reads 0.
- R3: A source whose enable bit is 0 is never requested. While the global bit is 0, irq_req stays 0.
- R4: Bit i of the priority register (1 = high) sets the level of source i. An eligible high-level request always wins over a low-level one.
- R5: Among eligible requests at the same level, the lowest source index wins.
- R6: An accepted acknowledge (irq_ack while irq_req) marks the level of irq_hi as in service: svc_lvl[1] is high and svc_lvl[0] is low. While any level is in service, no low-level request is presented. While the high level is in service, no request is presented at all.
- R7: An irq_reti pulse clears the high in-service bit if it is set, and otherwise clears the low bit.
- R8: An accepted acknowledge clears the latched flag of sources 0..3. It leaves the serial and timer-2 requests pending.
- R9: An external or timer-0/1 strobe becomes visible on irq_req one clock after the strobe. Timer-2 inputs are visible in the same cycle.
- R10: The timer-2 request is the OR of t2_ovf and t2_ext.
- R11: wake is high whenever the global enable is set and any enabled source is pending. In-service state has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_evt | input | 2 | External event strobes (bit 0 = external 0) |
| tmr_ovf | input | 2 | Timer 0/1 overflow strobes |
| ser_req | input | 1 | Serial-port request level, cleared by software |
| t2_ovf | input | 1 | Timer-2 overflow flag level |
| t2_ext | input | 1 | Timer-2 external flag level |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| pri_wr | input | 1 | Priority register write strobe |
| pri_wdata | input | 6 | Priority register write data |
| irq_ack | input | 1 | CPU takes the presented vector |
| irq_reti | input | 1 | Return from interrupt |
| irq_req | output | 1 | Request to the CPU |
| irq_idx | output | 3 | Index of the presented source |
| irq_hi | output | 1 | Presented request is high level |
| svc_lvl | output | 2 | In-service bits (1 = high, 0 = low) |
| en_rdata | output | 8 | Enable register readback |
| pri_rdata | output | 6 | Priority register readback |
| wake | output | 1 | Idle-mode wake indication |

## Verification
The bench holds all six sources pending and sweeps every combination of enable and priority patterns, with the global bit both off and on. A design that mis-ordered the levels or the same-level order would present the wrong index here. A design that leaked a masked source would present one when none is eligible.

Directed sequences cover several other cases:
- Timing: a design that registered the timer-2 inputs would show its request one cycle late. A design that passed timer-0 straight through would show its request one cycle early.
- Flag clearing: a design that cleared the serial or timer-2 request on acknowledge would lose the re-request after return. A design that left an edge flag set would re-request the same source after return.
- Nesting: a design with wrong nesting would let a low request through under a low handler, or block the high preemption. A wrong return order would release the low level first.

// File: rtl/intc_pkg.sv
// Shared constants for the two-level interrupt controller.
// Assumes exactly six sources; indices double as same-level priority order.
package intc_pkg;
    localparam int NUM_SRC  = 6;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int SRC_EXT0 = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_EXT1 = 2;
    localparam int SRC_TMR1 = 3;
    localparam int SRC_SER  = 4;
    localparam int SRC_TMR2 = 5;
    localparam int NUM_LATCHED = 4;
endpackage

// File: rtl/intc_cfg.sv
// Enable and priority registers with readback.
// Assumes the enable register is NSRC+2 bits: global at the top, one
// unimplemented bit below it that reads 0, per-source bits underneath.
module intc_cfg #(
    parameter int NSRC = intc_pkg::NUM_SRC,
    localparam int REG_W = NSRC + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic [REG_W-1:0] en_wdata,
    input  logic             pri_wr,
    input  logic [NSRC-1:0]  pri_wdata,
    output logic [NSRC-1:0]  src_en,
    output logic             glb_en,
    output logic [NSRC-1:0]  pri_q,
    output logic [REG_W-1:0] en_rdata
);
    // Enable register: global and per-source bits; the spare bit is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_en <= '0;
            glb_en <= 1'b0;
        end else if (en_wr) begin
            src_en <= en_wdata[NSRC-1:0];
            glb_en <= en_wdata[REG_W-1];
        end
    end

    // Priority register: one level bit per source.
    always_ff @(posedge clk) begin
        if (!rst_n)      pri_q <= '0;
        else if (pri_wr) pri_q <= pri_wdata;
    end

    // Readback with the unimplemented bit forced low.
    assign en_rdata = {glb_en, 1'b0, src_en};
endmodule

// File: rtl/intc_flags.sv
// Request flag capture. External and timer-0/1 strobes set a flag that
// persists until the vector is taken; serial and timer-2 are level inputs
// owned and cleared elsewhere. Assumes strobes last one clock.
module intc_flags #(
    parameter int NSRC = intc_pkg::NUM_SRC,
    localparam int IDX_W = $clog2(NSRC),
    localparam int NLAT  = intc_pkg::NUM_LATCHED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ext_evt,
    input  logic [1:0]       tmr_ovf,
    input  logic             ser_req,
    input  logic             t2_ovf,
    input  logic             t2_ext,
    input  logic             ack_fire,
    input  logic [IDX_W-1:0] ack_idx,
    output logic [NSRC-1:0]  pend
);
    import intc_pkg::*;

    logic [NLAT-1:0] set_vec;
    logic [NLAT-1:0] flag_q;

    // Map strobes onto their source positions.
    always_comb begin
        set_vec           = '0;
        set_vec[SRC_EXT0] = ext_evt[0];
        set_vec[SRC_TMR0] = tmr_ovf[0];
        set_vec[SRC_EXT1] = ext_evt[1];
        set_vec[SRC_TMR1] = tmr_ovf[1];
    end

    for (genvar g = 0; g < NLAT; g++) begin : g_lat
        // Latched flag: a new strobe wins over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else if (set_vec[g])
                flag_q[g] <= 1'b1;
            else if (ack_fire && ack_idx == IDX_W'(g))
                flag_q[g] <= 1'b0;
        end
    end

    // Pending vector: latched flags plus pass-through levels.
    always_comb begin
        pend                = '0;
        pend[NLAT-1:0]      = flag_q;
        pend[SRC_SER]       = ser_req;
        pend[SRC_TMR2]      = t2_ovf | t2_ext;
    end
endmodule

// File: rtl/intc_resolve.sv
// Priority resolution and nesting filter. Combinational only.
// Assumes a lower index wins among requests at one level.
module intc_resolve #(
    parameter int NSRC = intc_pkg::NUM_SRC,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  src_en,
    input  logic             glb_en,
    input  logic [NSRC-1:0]  pri_q,
    input  logic             svc_hi,
    input  logic             svc_lo,
    output logic             req,
    output logic [IDX_W-1:0] idx,
    output logic             hi,
    output logic             wake
);
    logic [NSRC-1:0] live;
    logic [NSRC-1:0] elig_hi;
    logic [NSRC-1:0] elig_lo;
    logic [NSRC-1:0] pick;

    // Masked requests split by level, then gated by in-service state.
    always_comb begin
        live    = pend & src_en & {NSRC{glb_en}};
        elig_hi = (svc_hi) ? '0 : (live & pri_q);
        elig_lo = (svc_hi || svc_lo) ? '0 : (live & ~pri_q);
        hi      = |elig_hi;
        pick    = hi ? elig_hi : elig_lo;
        req     = |pick;
        wake    = |live;
    end

    // Find-first-set: scan downward so the lowest index is left standing.
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pick[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/intc_svc.sv
// In-service level tracker. Return releases the high level first.
// Assumes a return and an acknowledge in one cycle act in that order.
module intc_svc (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_fire,
    input  logic ack_hi,
    input  logic reti,
    output logic svc_hi,
    output logic svc_lo
);
    logic nxt_hi;
    logic nxt_lo;

    // Next-state: release on return, then mark the acknowledged level.
    always_comb begin
        nxt_hi = svc_hi;
        nxt_lo = svc_lo;
        if (reti) begin
            if (svc_hi) nxt_hi = 1'b0;
            else        nxt_lo = 1'b0;
        end
        if (ack_fire) begin
            if (ack_hi) nxt_hi = 1'b1;
            else        nxt_lo = 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_hi <= 1'b0;
            svc_lo <= 1'b0;
        end else begin
            svc_hi <= nxt_hi;
            svc_lo <= nxt_lo;
        end
    end
endmodule

// File: rtl/intc_two_level.sv
// Top of the two-level interrupt controller: config registers, flag
// capture, resolution and in-service tracking. Assumes the CPU acks
// only while irq_req is high; a stray ack is ignored.
module intc_two_level (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ext_evt,
    input  logic [1:0] tmr_ovf,
    input  logic       ser_req,
    input  logic       t2_ovf,
    input  logic       t2_ext,
    input  logic       en_wr,
    input  logic [7:0] en_wdata,
    input  logic       pri_wr,
    input  logic [5:0] pri_wdata,
    input  logic       irq_ack,
    input  logic       irq_reti,
    output logic       irq_req,
    output logic [2:0] irq_idx,
    output logic       irq_hi,
    output logic [1:0] svc_lvl,
    output logic [7:0] en_rdata,
    output logic [5:0] pri_rdata,
    output logic       wake
);
    import intc_pkg::*;

    logic [NUM_SRC-1:0] src_en;
    logic               glb_en;
    logic [NUM_SRC-1:0] pend;
    logic               svc_hi;
    logic               svc_lo;
    logic               ack_fire;

    assign ack_fire = irq_ack & irq_req;
    assign svc_lvl  = {svc_hi, svc_lo};

    intc_cfg #(.NSRC(NUM_SRC)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .en_wr(en_wr), .en_wdata(en_wdata),
        .pri_wr(pri_wr), .pri_wdata(pri_wdata),
        .src_en(src_en), .glb_en(glb_en),
        .pri_q(pri_rdata), .en_rdata(en_rdata)
    );

    intc_flags #(.NSRC(NUM_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .ext_evt(ext_evt), .tmr_ovf(tmr_ovf), .ser_req(ser_req),
        .t2_ovf(t2_ovf), .t2_ext(t2_ext),
        .ack_fire(ack_fire), .ack_idx(irq_idx),
        .pend(pend)
    );

    intc_resolve #(.NSRC(NUM_SRC)) u_resolve (
        .pend(pend), .src_en(src_en), .glb_en(glb_en), .pri_q(pri_rdata),
        .svc_hi(svc_hi), .svc_lo(svc_lo),
        .req(irq_req), .idx(irq_idx), .hi(irq_hi), .wake(wake)
    );

    intc_svc u_svc (
        .clk(clk), .rst_n(rst_n),
        .ack_fire(ack_fire), .ack_hi(irq_hi), .reti(irq_reti),
        .svc_hi(svc_hi), .svc_lo(svc_lo)
    );
endmodule

// File: rtl/intc_chk.sv
// Property checker for intc_two_level, attached by bind.
module intc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       t2_ovf,
    input logic       t2_ext,
    input logic       irq_ack,
    input logic       irq_reti,
    input logic       irq_req,
    input logic [2:0] irq_idx,
    input logic       irq_hi,
    input logic [1:0] svc_lvl,
    input logic [7:0] en_rdata,
    input logic       wake
);
    AST_SPARE_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        en_rdata[6] == 1'b0);                                            // R2
    AST_REQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (en_rdata[7] && en_rdata[irq_idx]));                 // R3
    AST_HI_SVC_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        svc_lvl[1] |-> !irq_req);                                        // R6
    AST_LO_SVC_ONLY_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_lvl[0] && irq_req) |-> irq_hi);                             // R6
    AST_ACK_MARKS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && irq_hi) |=> svc_lvl[1]);                  // R6
    AST_RETI_DROPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_reti && svc_lvl[1] && !irq_ack) |=> !svc_lvl[1]);           // R7
    AST_T2_OR_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rdata[7] && en_rdata[5] && (t2_ovf || t2_ext)) |-> wake);    // R10
    AST_REQ_IMPLIES_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wake);                                               // R11
endmodule

bind intc_two_level intc_chk i_chk (.*);

// File: tb/test_intc_two_level.sv
module test_intc_two_level;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_evt = '0;
    logic [1:0] tmr_ovf = '0;
    logic       ser_req = 1'b0;
    logic       t2_ovf = 1'b0;
    logic       t2_ext = 1'b0;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic       pri_wr = 1'b0;
    logic [5:0] pri_wdata = '0;
    logic       irq_ack = 1'b0;
    logic       irq_reti = 1'b0;
    logic       irq_req;
    logic [2:0] irq_idx;
    logic       irq_hi;
    logic [1:0] svc_lvl;
    logic [7:0] en_rdata;
    logic [5:0] pri_rdata;
    logic       wake;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intc_two_level i_intc_two_level (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected {req, hi, idx} from the requirements.
    function automatic logic [4:0] model(input logic [5:0] pend, input logic [5:0] en,
                                         input logic [5:0] pri, input logic g,
                                         input logic shi, input logic slo);
        logic [5:0] live;
        live = pend & en & {6{g}};
        if (!shi)
            for (int i = 0; i < 6; i++)
                if (live[i] && pri[i]) return {2'b11, 3'(i)};
        if (!shi && !slo)
            for (int i = 0; i < 6; i++)
                if (live[i] && !pri[i]) return {2'b10, 3'(i)};
        return 5'b0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ext_evt = '0; tmr_ovf = '0; ser_req = 0; t2_ovf = 0; t2_ext = 0;
        en_wr = 0; pri_wr = 0; irq_ack = 0; irq_reti = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic [7:0] en, input logic [5:0] pri);
        @(negedge clk);
        en_wr = 1; en_wdata = en; pri_wr = 1; pri_wdata = pri;
        @(negedge clk);
        en_wr = 0; pri_wr = 0;
        #1;
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0; #1;
    endtask

    task automatic pulse_reti();
        @(negedge clk); irq_reti = 1;
        @(negedge clk); irq_reti = 0; #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [4:0] e;
        do_reset();
        #1;
        // R1: reset state
        chk("R1 req", irq_req, 0);
        chk("R1 wake", wake, 0);
        chk("R1 en", en_rdata, 0);
        chk("R1 pri", pri_rdata, 0);
        chk("R1 svc", svc_lvl, 0);

        // R2: spare bit reads zero
        write_cfg(8'hFF, 6'h00);
        chk("R2 en readback", en_rdata, 8'hBF);

        // Sweep: all sources pending, every enable/priority/global pattern (R3 R4 R5 R11)
        @(negedge clk);
        ext_evt = 2'b11; tmr_ovf = 2'b11; ser_req = 1; t2_ovf = 1;
        @(negedge clk);
        ext_evt = 0; tmr_ovf = 0;
        for (int g = 0; g < 2; g++) begin
            for (int p = 0; p < 64; p++) begin
                for (int en = 0; en < 64; en++) begin
                    @(negedge clk);
                    en_wr = 1; en_wdata = {g[0], 1'b0, en[5:0]};
                    pri_wr = 1; pri_wdata = p[5:0];
                    @(negedge clk);
                    en_wr = 0; pri_wr = 0;
                    #1;
                    e = model(6'h3F, en[5:0], p[5:0], g[0], 1'b0, 1'b0);
                    chk("R3/R4/R5 sweep", {irq_req, irq_hi, irq_idx}, e);
                    chk("R11 sweep wake", wake, int'(g[0] && en != 0));
                end
            end
        end

        // R9/R8/R7: timer-0 one cycle late, cleared by ack
        do_reset();
        write_cfg(8'hBF, 6'h00);
        @(negedge clk); tmr_ovf = 2'b01; #1;
        chk("R9 tmr0 not yet", irq_req, 0);
        @(negedge clk); tmr_ovf = 0; #1;
        chk("R9 tmr0 next cycle", {irq_req, irq_idx}, {1'b1, 3'd1});
        pulse_ack();
        chk("R6 lo in service", svc_lvl, 2'b01);
        pulse_reti();
        chk("R7 lo released", svc_lvl, 2'b00);
        chk("R8 tmr0 flag cleared", irq_req, 0);

        // R9/R10/R8: timer-2 same cycle, persists through ack
        @(negedge clk); t2_ext = 1; #1;
        chk("R9 tmr2 same cycle", {irq_req, irq_idx}, {1'b1, 3'd5});
        pulse_ack();
        pulse_reti();
        chk("R8 tmr2 persists", {irq_req, irq_idx}, {1'b1, 3'd5});
        @(negedge clk); t2_ext = 0; t2_ovf = 1; #1;
        chk("R10 ovf input alone", {irq_req, irq_idx}, {1'b1, 3'd5});
        @(negedge clk); t2_ovf = 0; #1;
        chk("R10 both low", irq_req, 0);

        // R6/R7/R11: nesting with serial at high level
        write_cfg(8'hBF, 6'h10);
        @(negedge clk); ext_evt = 2'b01;
        @(negedge clk); ext_evt = 0; #1;
        chk("R5 ext0 low presented", {irq_req, irq_hi, irq_idx}, {2'b10, 3'd0});
        pulse_ack();
        @(negedge clk); ser_req = 1; #1;
        chk("R6 hi preempts lo", {irq_req, irq_hi, irq_idx}, {2'b11, 3'd4});
        pulse_ack();
        chk("R6 both in service", svc_lvl, 2'b11);
        chk("R6 nothing under hi", irq_req, 0);
        chk("R11 wake under service", wake, 1);
        pulse_reti();
        chk("R7 hi released first", svc_lvl, 2'b01);
        chk("R8 serial persists", {irq_req, irq_idx}, {1'b1, 3'd4});
        @(negedge clk); ser_req = 0;
        @(negedge clk); ext_evt = 2'b10;
        @(negedge clk); ext_evt = 0; #1;
        chk("R6 lo blocked under lo", irq_req, 0);
        pulse_reti();
        chk("R7 lo released", {irq_req, irq_idx, svc_lvl}, {1'b1, 3'd2, 2'b00});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule